// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block is a hardware controller that takes a set of flash blocks chosen by a bit mask and erases them without help from software. A one-cycle start pulse captures the mask. The controller first programs every byte of each chosen block to zero. It then repeats a cycle of timed erase pulse followed by a verify sweep. During the verify sweep it visits each byte in turn: a dummy write latches the address, then a read checks that the byte reads back as fully erased. When a block passes, its mask bit is cleared, so later pulses and sweeps only touch blocks that still hold data.

The erase pulse starts at a configured length and doubles after each of the first few failed attempts. After that it keeps its last length. The attempt count has a ceiling; if it is reached, the controller reports an error and leaves the unerased blocks visible in its mask output. A watchdog enable frames every pulse. All time intervals are counted in clock cycles, and they are derived from a clock-frequency parameter unless they are overridden.

Top module: `flash_erase_seq`

## Requirements
- R1: After start with a nonzero mask, every address of every selected block receives one write strobe with data 0x00, blocks in ascending index order. This happens before the first erase pulse. Addresses in unselected blocks are never written with the verify mode low.
- R2: `wdt_en` is high in the cycle before `fl_erase` rises, stays high throughout the pulse and in the cycle after it falls, and is low in the cycle after that.
- R3: Erase pulse k (k = 1, 2, ...) lasts ERASE_INIT_CYC × 2^min(k-1, DBL_ATTEMPTS-1) clock cycles. With the default DBL_ATTEMPTS = 4, lengths double up to 8× and then stay fixed.
- R4: A configuration whose initial pulse exceeds 6.25 ms, or whose longest pulse exceeds 50 ms, fails elaboration. No measured pulse exceeds CLK_HZ/20 cycles.
- R5: Each verify sweep of a block raises `fl_verify`, holds it for exactly VS1_CYC cycles with no access, and then makes its first access at offset 0 of that block.
- R6: Each verify access is a write strobe with data 0xFF, followed by VS2_CYC wait cycles and one read cycle. Successive accesses within a sweep step the address by one, so accesses are VS2_CYC+2 cycles apart. A byte passes only if it reads 0xFF.
- R7: A read other than 0xFF ends the sweep. `fl_verify` drops, and a new erase pulse follows. `fl_erase` and `fl_verify` are never high together.
- R8: If a mismatch occurs after MAX_TRIES pulses, `err` pulses for one cycle, no further pulse is issued, and `blk_remain` keeps the bits of the blocks that did not pass.
- R9: A block that passes its last address has its `blk_remain` bit cleared. Later sweeps skip it, and it counts no further pulses. `done` pulses once all bits are clear.
- R10: `done` and `err` are single-cycle pulses. `start` is ignored while `busy` is high. The mask is taken from `blk_sel` only in the start cycle.
- R11: Start with an all-zero mask gives a `done` pulse in the next cycle, with no write, erase or verify activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an erase run |
| blk_sel | input | NUM_BLK | Blocks to erase, captured on start |
| busy | output | 1 | High from the cycle after start until the run ends |
| done | output | 1 | One-cycle pulse: all selected blocks erased |
| err | output | 1 | One-cycle pulse: attempt ceiling reached |
| blk_remain | output | NUM_BLK | Blocks still awaiting a successful verify |
| wdt_en | output | 1 | Watchdog enable framing each erase pulse |
| fl_erase | output | 1 | Erase mode control to the array |
| fl_verify | output | 1 | Erase-verify mode control to the array |
| fl_addr | output | ADDR_W | Array address: block index above byte offset |
| fl_wdata | output | 8 | Write data (0x00 prewrite, 0xFF dummy write) |
| fl_we | output | 1 | Write strobe |
| fl_rdata | input | 8 | Read data from the array |

## Verification
The bench uses 4 blocks of 4 bytes and CLK_HZ = 1000. At that clock the 6.25 ms and 50 ms limits become 6 and 50 cycles, so an initial pulse of 5 cycles makes the full doubling ladder 5, 10, 20, 40 and fits under the ceiling. VS1_CYC = 3 and VS2_CYC = 2 keep the verify spacing short but still distinct. MAX_TRIES = 7 instead of 602 lets the error case finish in a few hundred cycles after the pulse length has stopped growing.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_WDT_ON,
        S_PULSE,
        S_WDT_OFF,
        S_VS1,
        S_VWR,
        S_VS2,
        S_VRD,
        S_VEXIT,
        S_FIN,
        S_FAIL
    } fes_state_e;

    localparam logic [7:0] PREWRITE_BYTE = 8'h00;
    localparam logic [7:0] ERASED_BYTE   = 8'hFF;

    // Next pulse length after a failed attempt: doubles while the
    // attempt number that follows is still inside the doubling window.
    function automatic longint unsigned fes_next_len(
        input longint unsigned cur_len,
        input longint unsigned next_attempt,
        input longint unsigned dbl_attempts
    );
        return (next_attempt <= dbl_attempts) ? (cur_len << 1) : cur_len;
    endfunction

endpackage

// File: rtl/fes_timer.sv
module fes_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fes_pulse_sched.sv
module fes_pulse_sched import fes_pkg::*; #(
    parameter int CYC_W        = 8,
    parameter int N_W          = 4,
    parameter int INIT_CYC     = 4,
    parameter int DBL_ATTEMPTS = 4,
    parameter int MAX_TRIES    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             bump,
    output logic [CYC_W-1:0] pulse_len,
    output logic             exhausted
);
    logic [N_W-1:0]   attempt_q;
    logic [CYC_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            attempt_q <= '0;
            len_q     <= '0;
        end else if (init) begin
            attempt_q <= N_W'(1);
            len_q     <= CYC_W'(INIT_CYC);
        end else if (bump) begin
            attempt_q <= attempt_q + 1'b1;
            len_q     <= CYC_W'(fes_next_len(longint'(len_q),
                                             longint'(attempt_q) + 1,
                                             longint'(DBL_ATTEMPTS)));
        end
    end

    assign pulse_len = len_q;
    assign exhausted = (attempt_q >= N_W'(MAX_TRIES));
endmodule

// File: rtl/fes_addr_walk.sv
module fes_addr_walk #(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 4,
    parameter int BLK_W     = 2,
    parameter int OFF_W     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BLK-1:0] mask,
    input  logic               restart,
    input  logic               step,
    output logic [BLK_W-1:0]   blk,
    output logic [OFF_W-1:0]   off,
    output logic               last_off,
    output logic               more
);
    logic [BLK_W-1:0] blk_q;
    logic [OFF_W-1:0] off_q;
    logic [BLK_W-1:0] first_idx;
    logic [BLK_W-1:0] next_idx;
    logic             next_hit;

    always_comb begin
        first_idx = '0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (mask[i]) first_idx = BLK_W'(i);
        end
    end

    always_comb begin
        next_idx = '0;
        next_hit = 1'b0;
        for (int i = NUM_BLK - 1; i >= 0; i--) begin
            if (mask[i] && (i > int'(blk_q))) begin
                next_idx = BLK_W'(i);
                next_hit = 1'b1;
            end
        end
    end

    assign last_off = (off_q == OFF_W'(BLK_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
            off_q <= '0;
        end else if (restart) begin
            blk_q <= first_idx;
            off_q <= '0;
        end else if (step) begin
            if (last_off) begin
                blk_q <= next_idx;
                off_q <= '0;
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    assign blk  = blk_q;
    assign off  = off_q;
    assign more = next_hit;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq import fes_pkg::*; #(
    parameter int NUM_BLK        = 8,
    parameter int BLK_WORDS      = 1024,
    parameter int CLK_HZ         = 16_000_000,
    parameter int ERASE_INIT_CYC = (CLK_HZ / 1000) * 6,
    parameter int VS1_CYC        = (CLK_HZ * 4 + 999_999) / 1_000_000,
    parameter int VS2_CYC        = (CLK_HZ * 2 + 999_999) / 1_000_000,
    parameter int DBL_ATTEMPTS   = 4,
    parameter int MAX_TRIES      = 602,
    localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int OFF_W  = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NUM_BLK-1:0] blk_sel,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [NUM_BLK-1:0] blk_remain,
    output logic               wdt_en,
    output logic               fl_erase,
    output logic               fl_verify,
    output logic [ADDR_W-1:0]  fl_addr,
    output logic [7:0]         fl_wdata,
    output logic               fl_we,
    input  logic [7:0]         fl_rdata
);
    localparam longint MAX_PULSE   = longint'(ERASE_INIT_CYC) << (DBL_ATTEMPTS - 1);
    localparam longint INIT_LIMIT  = (longint'(CLK_HZ) * 625) / 100_000;
    localparam longint PULSE_LIMIT = longint'(CLK_HZ) / 20;
    localparam longint VS1_MIN     = (longint'(CLK_HZ) * 4 + 999_999) / 1_000_000;
    localparam longint VS2_MIN     = (longint'(CLK_HZ) * 2 + 999_999) / 1_000_000;
    localparam longint WAIT_MAX    = (MAX_PULSE > VS1_CYC)
                                     ? ((MAX_PULSE > VS2_CYC) ? MAX_PULSE : longint'(VS2_CYC))
                                     : ((VS1_CYC > VS2_CYC) ? longint'(VS1_CYC) : longint'(VS2_CYC));
    localparam int TMR_W = $clog2(WAIT_MAX + 1);
    localparam int N_W   = $clog2(MAX_TRIES + 1);

    // Configuration limits: rejected at elaboration.
    if (ERASE_INIT_CYC < 1 || longint'(ERASE_INIT_CYC) > INIT_LIMIT) begin : g_bad_init
        $error("initial erase pulse outside 1 cycle .. 6.25 ms");
    end
    if (MAX_PULSE > PULSE_LIMIT) begin : g_bad_pulse
        $error("longest erase pulse exceeds 50 ms");
    end
    if (VS1_CYC < 1 || longint'(VS1_CYC) < VS1_MIN ||
        VS2_CYC < 1 || longint'(VS2_CYC) < VS2_MIN) begin : g_bad_settle
        $error("verify settle times below minimum");
    end
    if (NUM_BLK < 1 || NUM_BLK > 32 || DBL_ATTEMPTS < 1 || MAX_TRIES < 1) begin : g_bad_shape
        $error("unsupported block count or attempt limits");
    end

    fes_state_e         state_q, state_d;
    logic [NUM_BLK-1:0] remain_q;
    logic               vfail_q;

    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_done;
    logic               sch_init, sch_bump, exhausted;
    logic [TMR_W-1:0]   pulse_len;
    logic [NUM_BLK-1:0] walk_mask;
    logic               walk_restart, walk_step;
    logic [BLK_W-1:0]   ag_blk;
    logic [OFF_W-1:0]   ag_off;
    logic               last_off, more;
    logic               rd_ok, clr_blk;

    fes_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    fes_pulse_sched #(
        .CYC_W(TMR_W), .N_W(N_W), .INIT_CYC(ERASE_INIT_CYC),
        .DBL_ATTEMPTS(DBL_ATTEMPTS), .MAX_TRIES(MAX_TRIES)
    ) u_sched (
        .clk(clk), .rst(rst), .init(sch_init), .bump(sch_bump),
        .pulse_len(pulse_len), .exhausted(exhausted)
    );

    assign walk_mask = (state_q == S_IDLE) ? blk_sel : remain_q;

    fes_addr_walk #(
        .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS), .BLK_W(BLK_W), .OFF_W(OFF_W)
    ) u_walk (
        .clk(clk), .rst(rst), .mask(walk_mask), .restart(walk_restart), .step(walk_step),
        .blk(ag_blk), .off(ag_off), .last_off(last_off), .more(more)
    );

    assign rd_ok = (fl_rdata == ERASED_BYTE);

    always_comb begin
        state_d      = state_q;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        sch_init     = 1'b0;
        sch_bump     = 1'b0;
        walk_restart = 1'b0;
        walk_step    = 1'b0;
        clr_blk      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (|blk_sel) begin
                        walk_restart = 1'b1;
                        state_d      = S_PRE;
                    end else begin
                        state_d = S_FIN;
                    end
                end
            end
            S_PRE: begin
                if (last_off && !more) begin
                    sch_init = 1'b1;
                    state_d  = S_WDT_ON;
                end else begin
                    walk_step = 1'b1;
                end
            end
            S_WDT_ON: begin
                tmr_load = 1'b1;
                tmr_val  = pulse_len - 1'b1;
                state_d  = S_PULSE;
            end
            S_PULSE: begin
                if (tmr_done) state_d = S_WDT_OFF;
            end
            S_WDT_OFF: begin
                tmr_load     = 1'b1;
                tmr_val      = TMR_W'(VS1_CYC - 1);
                walk_restart = 1'b1;
                state_d      = S_VS1;
            end
            S_VS1: begin
                if (tmr_done) state_d = S_VWR;
            end
            S_VWR: begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(VS2_CYC - 1);
                state_d  = S_VS2;
            end
            S_VS2: begin
                if (tmr_done) state_d = S_VRD;
            end
            S_VRD: begin
                if (!rd_ok) begin
                    state_d = S_VEXIT;
                end else if (last_off) begin
                    clr_blk = 1'b1;
                    state_d = S_VEXIT;
                end else begin
                    walk_step = 1'b1;
                    state_d   = S_VWR;
                end
            end
            S_VEXIT: begin
                if (vfail_q) begin
                    if (exhausted) begin
                        state_d = S_FAIL;
                    end else begin
                        sch_bump = 1'b1;
                        state_d  = S_WDT_ON;
                    end
                end else if (|remain_q) begin
                    tmr_load     = 1'b1;
                    tmr_val      = TMR_W'(VS1_CYC - 1);
                    walk_restart = 1'b1;
                    state_d      = S_VS1;
                end else begin
                    state_d = S_FIN;
                end
            end
            S_FIN:   state_d = S_IDLE;
            S_FAIL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            remain_q <= '0;
            vfail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start)
                remain_q <= blk_sel;
            else if (clr_blk)
                remain_q[ag_blk] <= 1'b0;
            if (state_q == S_VRD)
                vfail_q <= !rd_ok;
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_FIN);
    assign err        = (state_q == S_FAIL);
    assign blk_remain = remain_q;
    assign wdt_en     = (state_q == S_WDT_ON) || (state_q == S_PULSE) || (state_q == S_WDT_OFF);
    assign fl_erase   = (state_q == S_PULSE);
    assign fl_verify  = (state_q == S_VS1) || (state_q == S_VWR) ||
                        (state_q == S_VS2) || (state_q == S_VRD);
    assign fl_we      = (state_q == S_PRE) || (state_q == S_VWR);
    assign fl_wdata   = (state_q == S_VWR) ? ERASED_BYTE : PREWRITE_BYTE;
    assign fl_addr    = {ag_blk, ag_off};
endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
    parameter int NUM_BLK = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [NUM_BLK-1:0] blk_remain,
    input logic               wdt_en,
    input logic               fl_erase,
    input logic               fl_verify,
    input logic               fl_we,
    input logic [7:0]         fl_wdata
);
    assert_erase_wdt_R2: assert property (@(posedge clk) disable iff (rst)
        fl_erase |-> wdt_en);

    assert_wdt_lead_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_erase) |-> $past(wdt_en));

    assert_wdt_trail_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_erase) |-> wdt_en);

    assert_mode_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(fl_erase && fl_verify));

    assert_prewrite_data_R1: assert property (@(posedge clk) disable iff (rst)
        (fl_we && !fl_verify) |-> (fl_wdata == 8'h00 && !fl_erase));

    assert_dummy_data_R6: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_verify) |-> (fl_wdata == 8'hFF));

    assert_verify_settle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_verify) |-> !fl_we);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_erase && !fl_verify && !fl_we && !wdt_en));

    assert_mask_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((blk_remain & ~$past(blk_remain)) == '0));
endmodule

bind flash_erase_seq fes_checker #(.NUM_BLK(NUM_BLK)) u_fes_checker (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .blk_remain(blk_remain), .wdt_en(wdt_en), .fl_erase(fl_erase),
    .fl_verify(fl_verify), .fl_we(fl_we), .fl_wdata(fl_wdata)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
    localparam int NB    = 4;
    localparam int BW    = 4;
    localparam int HZ    = 1000;
    localparam int INIT  = 5;
    localparam int VS1   = 3;
    localparam int VS2   = 2;
    localparam int TRIES = 7;
    localparam int NADDR = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NB-1:0] blk_sel = '0;
    logic          busy, done, err, wdt_en, fl_erase, fl_verify, fl_we;
    logic [NB-1:0] blk_remain;
    logic [3:0]    fl_addr;
    logic [7:0]    fl_wdata;
    logic [7:0]    fl_rdata;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .NUM_BLK(NB), .BLK_WORDS(BW), .CLK_HZ(HZ), .ERASE_INIT_CYC(INIT),
        .VS1_CYC(VS1), .VS2_CYC(VS2), .DBL_ATTEMPTS(4), .MAX_TRIES(TRIES)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .blk_sel(blk_sel),
        .busy(busy), .done(done), .err(err), .blk_remain(blk_remain),
        .wdt_en(wdt_en), .fl_erase(fl_erase), .fl_verify(fl_verify),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_rdata(fl_rdata)
    );

    // Array stub and observation state
    int need    [NB];
    int bpulses [NB];
    int vw      [NB];
    bit pw_mark [NADDR];
    int plen    [16];
    int npulse, cur_len, wdt_bad, pw_bad, v_bad, vcnt, gap;
    bit p_erase, p_wdt, p_verify, after_fall, first_w;
    logic [3:0] last_waddr;

    always_comb begin
        if (bpulses[fl_addr[3:2]] >= need[fl_addr[3:2]] || fl_addr[1:0] != 2'(BW - 1))
            fl_rdata = 8'hFF;
        else
            fl_rdata = 8'h00;
    end

    always @(negedge clk) begin
        if (rst || (start && !busy)) begin
            for (int b = 0; b < NB; b++) begin bpulses[b] = 0; vw[b] = 0; end
            for (int a = 0; a < NADDR; a++) pw_mark[a] = 1'b0;
            npulse = 0; cur_len = 0; wdt_bad = 0; pw_bad = 0; v_bad = 0;
            vcnt = 0; gap = 0; after_fall = 1'b0; first_w = 1'b0;
            last_waddr = '0;
        end else begin
            if (fl_erase) cur_len++;
            if (fl_erase && !p_erase && !p_wdt) wdt_bad++;
            if (!fl_erase && p_erase) begin
                if (npulse < 16) plen[npulse] = cur_len;
                npulse++;
                cur_len = 0;
                if (!wdt_en) wdt_bad++;
                for (int b = 0; b < NB; b++) if (blk_remain[b]) bpulses[b]++;
                after_fall = 1'b1;
            end else if (after_fall) begin
                after_fall = 1'b0;
                if (wdt_en) wdt_bad++;
            end
            if (fl_we && !fl_verify) begin
                pw_mark[fl_addr] = 1'b1;
                if (fl_wdata != 8'h00 || npulse > 0 || fl_erase) pw_bad++;
            end
            if (fl_verify && !p_verify) begin vcnt = 0; first_w = 1'b1; end
            if (fl_verify) gap++;
            if (fl_verify && !fl_we && first_w) vcnt++;
            if (fl_verify && fl_we) begin
                vw[fl_addr[3:2]]++;
                if (fl_wdata != 8'hFF) v_bad++;
                if (first_w) begin
                    if (vcnt != VS1 || fl_addr[1:0] != 2'd0) v_bad++;
                    first_w = 1'b0;
                end else if (gap != VS2 + 2 || fl_addr != last_waddr + 4'd1) begin
                    v_bad++;
                end
                gap = 0;
                last_waddr = fl_addr;
            end
        end
        p_erase  = fl_erase;
        p_wdt    = wdt_en;
        p_verify = fl_verify;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int k);
        return INIT << ((k < 3) ? k : 3);
    endfunction

    task automatic run(input logic [NB-1:0] mask, input logic [NB-1:0] noise,
                       output bit got_done, output bit got_err);
        int n;
        got_done = 1'b0;
        got_err  = 1'b0;
        @(posedge clk); #1; blk_sel = mask; start = 1'b1;
        @(posedge clk); #1; start = 1'b0; blk_sel = noise;
        if (mask != '0) begin
            repeat (3) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        n = 0;
        while (!done && !err && n < 20000) begin
            @(negedge clk);
            n++;
        end
        got_done = done;
        got_err  = err;
        @(negedge clk);
        chk(!done && !err, "R10", "done/err single cycle", {done, err}, 0);
    endtask

    task automatic check_prewrite(input logic [NB-1:0] mask);
        int miss = 0;
        for (int a = 0; a < NADDR; a++) if (pw_mark[a] != mask[a / BW]) miss++;
        chk(miss == 0, "R1", "prewrite coverage mismatches", miss, 0);
        chk(pw_bad == 0, "R1", "prewrite data/order faults", pw_bad, 0);
    endtask

    task automatic check_common();
        chk(wdt_bad == 0, "R2", "watchdog framing faults", wdt_bad, 0);
        chk(v_bad == 0, "R5", "verify entry/spacing faults (R6)", v_bad, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R10", "idle outputs after reset", {busy, done, err}, 0);
        chk(!wdt_en && !fl_erase && !fl_verify && !fl_we, "R2", "controls low after reset",
            {wdt_en, fl_erase, fl_verify, fl_we}, 0);
        chk(blk_remain == '0, "R9", "mask empty after reset", blk_remain, 0);
    endtask

    task automatic t_single();
        bit d, e;
        need = '{1, 1, 1, 1};
        run(4'b0001, 4'b1111, d, e);
        chk(d && !e, "R9", "single block finished", d, 1);
        check_prewrite(4'b0001);
        check_common();
        chk(npulse == 1, "R3", "single block pulse count", npulse, 1);
        chk(plen[0] == INIT, "R3", "first pulse length", plen[0], INIT);
        chk(vw[0] == BW, "R6", "verify accesses block 0", vw[0], BW);
        chk(blk_remain == '0, "R9", "mask cleared", blk_remain, 0);
    endtask

    task automatic t_doubling();
        bit d, e;
        need = '{1, 1, 6, 1};
        run(4'b0100, 4'b0000, d, e);
        chk(d && !e, "R7", "retries lead to completion", d, 1);
        check_prewrite(4'b0100);
        check_common();
        chk(npulse == 6, "R7", "retry pulse count", npulse, 6);
        for (int k = 0; k < 6; k++) begin
            chk(plen[k] == exp_len(k), "R3", $sformatf("pulse %0d length", k + 1),
                plen[k], exp_len(k));
            chk(plen[k] <= HZ / 20, "R4", "pulse within 50 ms bound", plen[k], HZ / 20);
        end
        chk(vw[2] == 6 * BW, "R6", "verify accesses over six sweeps", vw[2], 6 * BW);
    endtask

    task automatic t_multi();
        bit d, e;
        need = '{1, 3, 1, 2};
        run(4'b1011, 4'b0100, d, e);
        chk(d && !e, "R9", "multi-block finished", d, 1);
        check_prewrite(4'b1011);
        check_common();
        chk(npulse == 3, "R10", "pulses with busy start ignored", npulse, 3);
        chk(bpulses[0] == 1, "R9", "passed block 0 not re-erased", bpulses[0], 1);
        chk(bpulses[1] == 3, "R9", "block 1 erase count", bpulses[1], 3);
        chk(bpulses[3] == 3, "R9", "block 3 erase count", bpulses[3], 3);
        chk(bpulses[2] == 0, "R10", "captured mask excludes block 2", bpulses[2], 0);
        chk(vw[0] == BW, "R9", "block 0 verified once", vw[0], BW);
        chk(vw[1] == 3 * BW, "R7", "block 1 verified each round", vw[1], 3 * BW);
        chk(vw[3] == BW, "R7", "block 3 reached only after block 1 passes", vw[3], BW);
    endtask

    task automatic t_error();
        bit d, e;
        need = '{1, 100, 1, 1};
        run(4'b0010, 4'b0000, d, e);
        chk(e && !d, "R8", "error reported", e, 1);
        check_common();
        chk(npulse == TRIES, "R8", "pulses before giving up", npulse, TRIES);
        chk(plen[TRIES - 1] == INIT * 8, "R3", "last pulse stays at 8x", plen[TRIES - 1], INIT * 8);
        chk(blk_remain == 4'b0010, "R8", "unerased block left in mask", blk_remain, 2);
        repeat (5) @(negedge clk);
        chk(!fl_erase && !busy, "R8", "no pulse after error", {fl_erase, busy}, 0);
    endtask

    task automatic t_empty();
        @(posedge clk); #1; blk_sel = '0; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R11", "done one cycle after empty start", done, 1);
        @(negedge clk);
        chk(npulse == 0 && !done, "R11", "no pulse, single done", npulse, 0);
        check_prewrite(4'b0000);
        chk(vw[0] + vw[1] + vw[2] + vw[3] == 0, "R11", "no verify access",
            vw[0] + vw[1] + vw[2] + vw[3], 0);
    endtask

    initial begin
        for (int b = 0; b < NB; b++) need[b] = 1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_doubling();
        t_multi();
        t_error();
        t_empty();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule